// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block picks which of three oscillators drives the system clock: a primary external oscillator, a slow secondary oscillator, or an on-chip internal oscillator. Software writes a 2-bit select field, together with a 4-bit internal frequency code, through a single-cycle write strobe in the control clock domain. Code 00 defers to a static 2-bit configuration input. Code 01 asks for the secondary oscillator. Any code with the upper bit set asks for the internal oscillator.

A switch starts only when the requested source reports that it is ready. The old clock is then gated off inside its own domain. Only after the controller sees that the old clock has stopped does it ask the new source's domain to start. That domain synchronizes the request, lets a set number of its own cycles pass so the oscillator can settle, and then opens its gate on a falling edge. The gated clocks are OR-ed together to form the system clock.

Status outputs give back the stored fields, the source that is driving now, a flag that is high only when the primary oscillator drives, and a busy flag. The busy flag covers both a switch in progress and a switch that is waiting for a ready signal.

Top module: `sysclk_switch`

## Requirements
- R1: While `rst` is high, and on the first control cycle after it is released, `sel_o` reads 00, `int_freq_o` reads 0 and `busy_o` reads 0. The driving source is the one that select code 00 resolves to under `cfg_src_i`.
- R2: Select code 00 resolves to the primary oscillator when `cfg_src_i` is 00, 01 or 10, and to the internal oscillator when `cfg_src_i` is 11. `cur_src_o` encodes the driving source as 0 for primary, 1 for secondary and 2 for internal.
- R3: A switch to a target begins only while that target is ready. The secondary oscillator counts as ready only when `sec_en_i` and `sec_rdy_i` are both high. The primary uses `pri_rdy_i` and the internal uses `int_rdy_i`. Until then, the old source keeps driving `sys_clk_o` and the switch stays pending.
- R4: Select code 01 resolves to the secondary oscillator. Codes 10 and 11 resolve to the internal oscillator. Each write stores `wr_freq_i`, which is then presented on `int_freq_o`.
- R5: `pri_active_o` is 1 while the primary drives the system clock. It is 0 while either the internal or the secondary oscillator drives.
- R6: After a write that needs a switch, `busy_o` is high within two control cycles. It stays high until the new source drives `sys_clk_o`, and is low once the switch has finished.
- R7: A write whose code resolves to the source already driving starts no switch, and `busy_o` stays low.
- R8: At most one source gate is requested at any time, and the old gate is closed before the new one is requested. No high or low phase on `sys_clk_o` is shorter than the shortest half period of the sources.
- R9: A newly requested source is gated onto the output only after it has run `DLY_*` cycles of its own clock. The time from the write to the end of `busy_o` is therefore at least `DLY_*` periods of the target clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctl_clk | input | 1 | Control clock for the register write and the switch sequencer |
| rst | input | 1 | Synchronous active-high reset; must be held for several cycles of the slowest source |
| clk_pri_i | input | 1 | Primary oscillator clock |
| clk_sec_i | input | 1 | Secondary low-frequency oscillator clock |
| clk_int_i | input | 1 | Internal oscillator clock |
| pri_rdy_i | input | 1 | Primary oscillator stable |
| sec_en_i | input | 1 | Secondary oscillator enable |
| sec_rdy_i | input | 1 | Secondary oscillator stable |
| int_rdy_i | input | 1 | Internal oscillator stable |
| cfg_src_i | input | 2 | Static configuration; 11 makes code 00 mean internal, any other value means primary |
| wr_en_i | input | 1 | Write strobe for the select and frequency fields |
| wr_sel_i | input | 2 | Select code to store |
| wr_freq_i | input | 4 | Internal frequency code to store |
| sys_clk_o | output | 1 | Glitch-free system clock |
| sel_o | output | 2 | Stored select code |
| int_freq_o | output | 4 | Stored internal frequency code |
| cur_src_o | output | 2 | Driving source: 0 primary, 1 secondary, 2 internal |
| pri_active_o | output | 1 | 1 while the primary drives the system clock |
| busy_o | output | 1 | Switch pending or in progress |

## Verification
The bench writes codes that alias to the same source, such as 10 followed by 11, or 00 while the primary is already driving. A design that compares raw codes instead of resolved sources would raise busy and stall the clock. It drops the secondary ready or enable, and the internal ready, and then writes to that target. A design that ignores readiness would hand over to a dead clock, and the measured output period would change. It resets with the configuration at 11, which exposes a design that ties code 00 to the primary. It also measures every output phase and each write-to-idle time, which catches a mux that overlaps its enables or skips the settling count.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  // Map a select code and the static configuration to a source.
  function automatic src_e resolve_src(input logic [1:0] sel, input logic [1:0] cfg);
    if (sel[1])            return SRC_INT;
    else if (sel[0])       return SRC_SEC;
    else if (cfg == 2'b11) return SRC_INT;
    else                   return SRC_PRI;
  endfunction
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic d,
  output logic q
);
  logic [SYNC_N-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= {SYNC_N{rst_val}};
    else     sh_q <= {sh_q[SYNC_N-2:0], d};
  end

  assign q = sh_q[SYNC_N-1];
endmodule

// File: rtl/clksw_gate.sv
module clksw_gate #(
  parameter int DLY    = 4,
  parameter int SYNC_N = 2
) (
  input  logic src_clk,
  input  logic rst,
  input  logic rst_on,
  input  logic req,
  output logic gclk,
  output logic ack
);
  localparam int CW = $clog2(DLY + 1);

  logic          req_s;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          en_q;

  clksw_sync #(.SYNC_N(SYNC_N)) u_req_sync (
    .clk(src_clk), .rst(rst), .rst_val(rst_on), .d(req), .q(req_s)
  );

  // Settling counter in the source's own clock.
  always_ff @(posedge src_clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= rst_on;
    end else if (!req_s) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CW'(DLY - 1)) done_q <= 1'b1;
      else                       cnt_q  <= cnt_q + 1'b1;
    end
  end

  // The gate changes only while the source clock is low.
  always_ff @(negedge src_clk) begin
    if (rst) en_q <= rst_on;
    else     en_q <= req_s & done_q;
  end

  assign gclk = src_clk & en_q;
  assign ack  = en_q;

  // R9
  gate_settled_chk: assert property (@(negedge src_clk) disable iff (rst)
    $rose(en_q) |-> done_q);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      sel,
  input  logic [1:0]      cfg,
  input  logic [NSRC-1:0] rdy,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] req,
  output logic [1:0]      cur,
  output logic            busy,
  output logic            pri_active
);
  typedef enum logic [1:0] {ST_IDLE, ST_DROP, ST_RAISE} st_e;

  st_e             state_q;
  src_e            cur_q, tgt_q, want, rst_src;
  logic [NSRC-1:0] req_q, ack_s, rst_hot;
  logic            busy_q, pri_q;

  assign rst_src = resolve_src(2'b00, cfg);
  assign rst_hot = NSRC'(1) << rst_src;
  assign want    = resolve_src(sel, cfg);

  for (genvar i = 0; i < NSRC; i++) begin : g_ack
    clksw_sync #(.SYNC_N(SYNC_N)) u_ack_sync (
      .clk(clk), .rst(rst), .rst_val(rst_hot[i]), .d(ack[i]), .q(ack_s[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cur_q   <= rst_src;
      tgt_q   <= rst_src;
      req_q   <= rst_hot;
      busy_q  <= 1'b0;
      pri_q   <= (rst_src == SRC_PRI);
    end else begin
      busy_q <= (state_q != ST_IDLE) || (want != cur_q);
      pri_q  <= (cur_q == SRC_PRI);
      case (state_q)
        ST_IDLE: if (want != cur_q && rdy[want]) begin
          tgt_q        <= want;
          req_q[cur_q] <= 1'b0;
          state_q      <= ST_DROP;
        end
        ST_DROP: if (!ack_s[cur_q]) begin
          req_q[tgt_q] <= 1'b1;
          state_q      <= ST_RAISE;
        end
        ST_RAISE: if (ack_s[tgt_q]) begin
          cur_q   <= tgt_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req        = req_q;
  assign cur        = cur_q;
  assign busy       = busy_q;
  assign pri_active = pri_q;

  // R8
  req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_q));
  // R8
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_s));
  // R6
  busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (ack_s == (NSRC'(1) << cur_q)));
  // R6
  cur_move_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q != $past(cur_q)) |-> $past(busy_q));
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import clksw_pkg::*;
#(
  parameter int DLY_PRI = 8,
  parameter int DLY_SEC = 4,
  parameter int DLY_INT = 8,
  parameter int SYNC_N  = 2
) (
  input  logic       ctl_clk,
  input  logic       rst,
  input  logic       clk_pri_i,
  input  logic       clk_sec_i,
  input  logic       clk_int_i,
  input  logic       pri_rdy_i,
  input  logic       sec_en_i,
  input  logic       sec_rdy_i,
  input  logic       int_rdy_i,
  input  logic [1:0] cfg_src_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [3:0] wr_freq_i,
  output logic       sys_clk_o,
  output logic [1:0] sel_o,
  output logic [3:0] int_freq_o,
  output logic [1:0] cur_src_o,
  output logic       pri_active_o,
  output logic       busy_o
);
  localparam int DLY_T [NSRC] = '{DLY_PRI, DLY_SEC, DLY_INT};

  logic [1:0]      sel_q;
  logic [3:0]      freq_q;
  logic [NSRC-1:0] src_clk, gclk, req, ack, rdy, rst_on;
  src_e            rst_src;

  assign src_clk = {clk_int_i, clk_sec_i, clk_pri_i};
  assign rdy     = {int_rdy_i, sec_en_i & sec_rdy_i, pri_rdy_i};
  assign rst_src = resolve_src(2'b00, cfg_src_i);
  assign rst_on  = NSRC'(1) << rst_src;

  always_ff @(posedge ctl_clk) begin
    if (rst) begin
      sel_q  <= 2'b00;
      freq_q <= 4'h0;
    end else if (wr_en_i) begin
      sel_q  <= wr_sel_i;
      freq_q <= wr_freq_i;
    end
  end

  clksw_ctrl #(.SYNC_N(SYNC_N)) u_ctrl (
    .clk(ctl_clk), .rst(rst), .sel(sel_q), .cfg(cfg_src_i), .rdy(rdy),
    .ack(ack), .req(req), .cur(cur_src_o), .busy(busy_o),
    .pri_active(pri_active_o)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    clksw_gate #(.DLY(DLY_T[i]), .SYNC_N(SYNC_N)) u_gate (
      .src_clk(src_clk[i]), .rst(rst), .rst_on(rst_on[i]), .req(req[i]),
      .gclk(gclk[i]), .ack(ack[i])
    );
  end

  assign sys_clk_o  = |gclk;
  assign sel_o      = sel_q;
  assign int_freq_o = freq_q;

  // R1
  sel_reset_chk: assert property (@(posedge ctl_clk) disable iff (rst)
    $past(rst) |-> (sel_q == 2'b00 && freq_q == 4'h0));
  // R8
  gate_overlap_chk: assert property (@(posedge ctl_clk) disable iff (rst)
    $onehot0(ack));
endmodule

// File: tb/test_sysclk_switch.sv
`timescale 1ns/1ps
module test_sysclk_switch;
  logic ctl_clk = 0, clk_pri = 0, clk_sec = 0, clk_int = 0;
  logic rst = 1;
  logic pri_rdy = 1, sec_en = 1, sec_rdy = 1, int_rdy = 1;
  logic [1:0] cfg = 2'b00;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [3:0] wr_freq = 0;
  logic sys_clk, pri_act, busy;
  logic [1:0] sel_o, cur;
  logic [3:0] freq_o;

  always #4  ctl_clk = ~ctl_clk;
  always #5  clk_pri = ~clk_pri;
  always #15 clk_sec = ~clk_sec;
  always #3  clk_int = ~clk_int;

  sysclk_switch i_sysclk_switch (
    .ctl_clk(ctl_clk), .rst(rst), .clk_pri_i(clk_pri), .clk_sec_i(clk_sec),
    .clk_int_i(clk_int), .pri_rdy_i(pri_rdy), .sec_en_i(sec_en),
    .sec_rdy_i(sec_rdy), .int_rdy_i(int_rdy), .cfg_src_i(cfg),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_freq_i(wr_freq),
    .sys_clk_o(sys_clk), .sel_o(sel_o), .int_freq_o(freq_o),
    .cur_src_o(cur), .pri_active_o(pri_act), .busy_o(busy)
  );

  int checks = 0, fails = 0, runts = 0;
  bit mon_en = 0, first = 1;
  realtime t_edge, t_wr;

  // {sel, freq, expected source, expected primary flag}
  localparam logic [8:0] VEC [0:7] = '{
    {2'b01, 4'h0, 2'd1, 1'b0},
    {2'b10, 4'h5, 2'd2, 1'b0},
    {2'b11, 4'h9, 2'd2, 1'b0},
    {2'b00, 4'h2, 2'd0, 1'b1},
    {2'b00, 4'h3, 2'd0, 1'b1},
    {2'b11, 4'hF, 2'd2, 1'b0},
    {2'b01, 4'h7, 2'd1, 1'b0},
    {2'b00, 4'h1, 2'd0, 1'b1}
  };

  function automatic real period_of(input logic [1:0] s);
    return (s == 2'd0) ? 10.0 : (s == 2'd1) ? 30.0 : 6.0;
  endfunction
  function automatic real settle_of(input logic [1:0] s);
    return (s == 2'd0) ? 80.0 : (s == 2'd1) ? 120.0 : 48.0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Runt monitor on every phase of the system clock
  always @(sys_clk) begin
    if (mon_en) begin
      if (!first && ($realtime - t_edge) < 2.9) runts++;
      first = 0;
      t_edge = $realtime;
    end
  end

  task automatic do_reset(input logic [1:0] c);
    mon_en = 0;
    rst = 1; cfg = c;
    repeat (20) @(negedge ctl_clk);
    rst = 0;
    @(negedge ctl_clk);
    first = 1; mon_en = 1;
  endtask

  task automatic write(input logic [1:0] s, input logic [3:0] f);
    @(negedge ctl_clk);
    wr_en = 1; wr_sel = s; wr_freq = f;
    @(posedge ctl_clk);
    t_wr = $realtime;
    @(negedge ctl_clk);
    wr_en = 0;
  endtask

  task automatic check_period(input logic [1:0] s, input string req);
    realtime t0, p;
    repeat (10) @(negedge ctl_clk);
    @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk); p = $realtime - t0;
    chk((p > period_of(s) - 0.5) && (p < period_of(s) + 0.5), req,
        int'(p), int'(period_of(s)));
  endtask

  task automatic wait_idle(output bit ok);
    ok = 0;
    repeat (2) @(negedge ctl_clk);
    for (int k = 0; k < 400; k++) begin
      if (!busy) begin ok = 1; break; end
      @(negedge ctl_clk);
    end
  endtask

  task automatic hold_pending(input logic [1:0] src_now, input string req);
    repeat (100) @(negedge ctl_clk);
    chk(busy == 1'b1, req, busy, 1);
    chk(cur == src_now, req, cur, src_now);
    check_period(src_now, req);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    bit ok;
    logic [1:0] prev;
    do_reset(2'b00);
    // R1 reset state
    chk(sel_o == 2'b00, "R1", sel_o, 0);
    chk(freq_o == 4'h0, "R1", freq_o, 0);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(cur == 2'd0, "R2", cur, 0);
    chk(pri_act == 1'b1, "R5", pri_act, 1);
    check_period(2'd0, "R2");

    prev = 2'd0;
    for (int v = 0; v < 8; v++) begin
      logic [1:0] s, src;
      logic [3:0] f;
      logic p;
      {s, f, src, p} = VEC[v];
      write(s, f);
      if (src == prev) begin
        bit quiet = 1;
        for (int k = 0; k < 40; k++) begin
          if (busy) quiet = 0;
          @(negedge ctl_clk);
        end
        chk(quiet, "R7", !quiet, 0);
      end else begin
        @(negedge ctl_clk);
        chk(busy == 1'b1, "R6", busy, 1);
        wait_idle(ok);
        chk(ok, "R6", !ok, 0);
        chk(($realtime - t_wr) >= settle_of(src), "R9",
            int'($realtime - t_wr), int'(settle_of(src)));
      end
      chk(cur == src, (s == 2'b01) ? "R4 sec" : (s[1] ? "R4 int" : "R2"), cur, src);
      chk(pri_act == p, "R5", pri_act, p);
      chk(sel_o == s, "R4", sel_o, s);
      chk(freq_o == f, "R4", freq_o, f);
      check_period(src, "R8");
      prev = src;
    end

    // R3: secondary not ready
    sec_rdy = 0;
    write(2'b01, 4'h0);
    hold_pending(2'd0, "R3");
    sec_rdy = 1;
    wait_idle(ok);
    chk(ok && cur == 2'd1, "R3", cur, 1);
    write(2'b00, 4'h0); wait_idle(ok);
    chk(cur == 2'd0, "R3", cur, 0);

    // R3: secondary disabled
    sec_en = 0;
    write(2'b01, 4'h0);
    hold_pending(2'd0, "R3");
    sec_en = 1;
    wait_idle(ok);
    chk(ok && cur == 2'd1, "R3", cur, 1);

    // R3: internal not ready
    int_rdy = 0;
    write(2'b10, 4'h4);
    hold_pending(2'd1, "R3");
    int_rdy = 1;
    wait_idle(ok);
    chk(ok && cur == 2'd2, "R3", cur, 2);

    // R2: configuration 11 makes code 00 internal
    do_reset(2'b11);
    chk(cur == 2'd2, "R2", cur, 2);
    chk(pri_act == 1'b0, "R5", pri_act, 0);
    chk(busy == 1'b0, "R1", busy, 0);
    check_period(2'd2, "R2");
    write(2'b10, 4'h6);
    begin
      bit quiet = 1;
      for (int k = 0; k < 40; k++) begin
        if (busy) quiet = 0;
        @(negedge ctl_clk);
      end
      chk(quiet, "R7", !quiet, 0);
    end
    write(2'b01, 4'h0); wait_idle(ok);
    chk(cur == 2'd1, "R4", cur, 1);
    chk(pri_act == 1'b0, "R5", pri_act, 0);
    check_period(2'd1, "R8");

    // R8 no short phases over the whole run
    chk(runts == 0, "R8", runts, 0);
    finish_run();
  end
endmodule